// File: doc/BRIEF.md
# Dual-Slope / Single-Slope 8-bit PWM Timer

This block turns a compare value into a pulse-width-modulated waveform on a single output. An 8-bit counter advances on ticks from a selectable clock divider. In single-slope (fast) mode the counter sweeps upward and wraps, so one period is 256 ticks. In dual-slope (phase-correct) mode the counter runs up to the top and back down, so one period is 510 ticks and the output is centred in the period. An invert control gives the complement of the waveform.

Software writes four small registers through a one-cycle write port. A compare write goes into a holding buffer. The active compare value takes the buffer only when the counter is at its top value, so a period already in progress keeps its old duty. A sticky flag records every counter-equals-compare event. The interrupt request is that flag gated by an enable bit.

Top module: `pwm_timer8`

## Requirements
- R1: After reset, pwmOut is 0 and irq is 0. The counter, the compare buffer, the active compare value and the flag are all cleared, and the divider select is stopped.
- R2: In fast mode (control bit0 = 0) with divider factor N and active compare o, the period is 256·N clocks and the non-inverted output is high for o·N clocks of each period.
- R3: In phase-correct mode (control bit0 = 1) the counter goes up 0..255 and down 254..1. The period is 510·N clocks and the non-inverted output is high for (2·o−1)·N clocks when o ≥ 1.
- R4: With control bit1 = 1 the output is the complement of the non-inverted waveform, so its high time is the period minus the high time of R2 or R3.
- R5: Control bits 4:2 pick the divider: 0 stopped, 1 ÷1, 2 ÷8, 3 ÷64, 4 ÷256, 5 ÷1024, 6 and 7 stopped. While stopped, the counter does not move and pwmOut holds its level.
- R6: A write to address 1 loads only the buffer. The active compare value takes the buffer on the tick that leaves count 255. A write during a period does not change that period's high time, and the new value applies from the next period.
- R7: A compare value of 0 keeps the non-inverted output low in both modes. A value of 255 gives 255·N high and 1·N low per period in fast mode, and 509·N high in phase-correct mode.
- R8: The flag sets on any tick where the counter's new value equals the active compare. It stays set until a write to address 3 with bit0 = 1 clears it. If a set and a clear fall in the same cycle, the set wins.
- R9: The interrupt request is the flag ANDed with the enable bit, which is address 2 bit0. Setting the enable later raises irq for a flag that was already pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | 2 | Register select: 0 control, 1 compare buffer, 2 interrupt enable, 3 flag clear |
| wrData | input | 8 | Write data |
| pwmOut | output | 1 | PWM waveform |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land on the same clock edge: a software clear of the flag and a fresh compare match that sets it. The bench runs fast mode at ÷1 and uses the falling output edge to find the match cycle. It places a clear write exactly one period later, so the clear and the match meet on one edge. It then requires irq to stay high, and to drop on the next clear, which has no match beside it. A second collision is between a compare write and the load at the top of the count. The bench provokes it by writing just after a period begins, then measuring that period's high time and the next one's.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int CNT_W = 8;

  typedef struct packed {
    logic             tick;
    logic             phaseMode;
    logic             invert;
    logic             cmpWr;
    logic [CNT_W-1:0] cmpData;
    logic             flagClr;
  } tmrStrobe_t;
endpackage

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int SEL_W  = 3,
  parameter int PRE_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output tmrStrobe_t        strb,
  output logic              irqEn
);
  localparam int SEL_LSB = 2;
  localparam int DIV8_B  = 3;
  localparam int DIV64_B = 6;
  localparam int DIV256_B = 8;
  localparam int DIV1K_B = 10;

  logic             phaseReg;
  logic             invReg;
  logic [SEL_W-1:0] selReg;
  logic [PRE_W-1:0] preCnt;
  logic             tickNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseReg <= 1'b0;
      invReg   <= 1'b0;
      selReg   <= '0;
      irqEn    <= 1'b0;
      preCnt   <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
      if (wrEn) begin
        case (wrAddr)
          2'd0: begin
            phaseReg <= wrData[0];
            invReg   <= wrData[1];
            selReg   <= wrData[SEL_LSB +: SEL_W];
          end
          2'd2: irqEn <= wrData[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (selReg)
      3'd1:    tickNow = 1'b1;
      3'd2:    tickNow = &preCnt[DIV8_B-1:0];
      3'd3:    tickNow = &preCnt[DIV64_B-1:0];
      3'd4:    tickNow = &preCnt[DIV256_B-1:0];
      3'd5:    tickNow = &preCnt[DIV1K_B-1:0];
      default: tickNow = 1'b0;
    endcase
  end

  always_comb begin
    strb.tick      = tickNow;
    strb.phaseMode = phaseReg;
    strb.invert    = invReg;
    strb.cmpWr     = wrEn && (wrAddr == 2'd1);
    strb.cmpData   = wrData;
    strb.flagClr   = wrEn && (wrAddr == 2'd3) && wrData[0];
  end
endmodule

// File: rtl/pwm_timer_dp.sv
module pwm_timer_dp
  import pwm_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  output logic             level,
  output logic             flag,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] ocr,
  output logic             dirUp
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cmpBuf;
  logic [CNT_W-1:0] nxtCnt;
  logic [CNT_W-1:0] ocrEff;
  logic             nxtDir;
  logic             atTop;

  assign atTop  = (cnt == TOP);
  assign ocrEff = atTop ? cmpBuf : ocr;

  always_comb begin
    nxtCnt = cnt + 1'b1;
    nxtDir = 1'b1;
    if (strb.phaseMode) begin
      if (dirUp) begin
        if (atTop) begin
          nxtCnt = cnt - 1'b1;
          nxtDir = 1'b0;
        end
      end else if (cnt == '0) begin
        nxtCnt = cnt + 1'b1;
        nxtDir = 1'b1;
      end else begin
        nxtCnt = cnt - 1'b1;
        nxtDir = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      dirUp  <= 1'b1;
      ocr    <= '0;
      cmpBuf <= '0;
      level  <= 1'b0;
      flag   <= 1'b0;
    end else begin
      if (strb.cmpWr) cmpBuf <= strb.cmpData;
      if (strb.tick) begin
        cnt   <= nxtCnt;
        dirUp <= nxtDir;
        level <= (nxtCnt < ocrEff);
        if (atTop) ocr <= cmpBuf;
      end
      if (strb.tick && (nxtCnt == ocrEff)) flag <= 1'b1;
      else if (strb.flagClr)               flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwm_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  output logic       pwmOut,
  output logic       irq
);
  tmrStrobe_t       strb;
  logic             irqEn;
  logic             level;
  logic             flag;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ocr;
  logic             dirUp;

  pwm_timer_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .strb  (strb),
    .irqEn (irqEn)
  );

  pwm_timer_dp u_dp (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb),
    .level(level),
    .flag (flag),
    .cnt  (cnt),
    .ocr  (ocr),
    .dirUp(dirUp)
  );

  assign pwmOut = level ^ strb.invert;
  assign irq    = flag & irqEn;
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
  import pwm_timer_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             phaseMode,
  input logic             flagClr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] ocr,
  input logic             dirUp,
  input logic             level,
  input logic             flag
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assert_level_below_cmp_R2: assert property (@(posedge clk) disable iff (!rstN)
    level == (cnt < ocr));

  assert_fast_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !phaseMode && cnt == TOP) |=> (cnt == '0));

  assert_pc_turn_top_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && phaseMode && dirUp && cnt == TOP) |=> (cnt == TOP - 1'b1 && !dirUp));

  assert_pc_turn_bottom_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && phaseMode && !dirUp && cnt == '0) |=> (cnt == 1 && dirUp));

  assert_stop_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(cnt) && $stable(level)));

  assert_cmp_load_top_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(tick && cnt == TOP) |=> $stable(ocr));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !flagClr) |=> flag);
endmodule

bind pwm_timer8 pwm_timer_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tick     (strb.tick),
  .phaseMode(strb.phaseMode),
  .flagClr  (strb.flagClr),
  .cnt      (cnt),
  .ocr      (ocr),
  .dirUp    (dirUp),
  .level    (level),
  .flag     (flag)
);

// File: tb/tb_pwm_timer8.sv
`timescale 1ns/1ps
module tb_pwm_timer8;
  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn;
  logic [1:0] wrAddr;
  logic [7:0] wrData;
  logic       pwmOut;
  logic       irq;
  int         checks = 0;
  int         errors = 0;

  pwm_timer8 dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pwmOut(pwmOut), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic cfg(input bit mode, input bit inv, input logic [2:0] sel);
    wr(2'd0, {3'b000, sel, inv, mode});
  endtask

  function automatic int expPer(input bit mode, input int n);
    return (mode ? 510 : 256) * n;
  endfunction

  function automatic int expHigh(input bit mode, input bit inv, input int o, input int n);
    int h;
    int p;
    p = mode ? 510 : 256;
    h = mode ? (2 * o - 1) : o;
    if (inv) h = p - h;
    return h * n;
  endfunction

  // measure one period from a rising edge; optional compare write right after the rise
  task automatic measure(output int hi, output int per, input bit doWr, input logic [7:0] newCmp);
    logic p;
    p = pwmOut;
    @(negedge clk);
    while (!(pwmOut && !p)) begin
      p = pwmOut;
      @(negedge clk);
    end
    hi = 0; per = 0;
    while (pwmOut) begin
      if (doWr && hi == 0) begin
        wrEn = 1'b1; wrAddr = 2'd1; wrData = newCmp;
      end
      hi++; per++;
      @(negedge clk);
      wrEn = 1'b0;
    end
    while (!pwmOut) begin
      per++;
      @(negedge clk);
    end
  endtask

  task automatic runCase(input bit mode, input bit inv, input int o,
                         input logic [2:0] sel, input int n, input string req);
    int hi;
    int per;
    cfg(mode, inv, sel);
    wr(2'd1, o[7:0]);
    measure(hi, per, 1'b0, 8'd0);
    measure(hi, per, 1'b0, 8'd0);
    chk(hi == expHigh(mode, inv, o, n), {req, " high time"}, hi, expHigh(mode, inv, o, n));
    chk(per == expPer(mode, n), {req, " period"}, per, expPer(mode, n));
  endtask

  task automatic countHigh(input int cycles, output int highs);
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwmOut) highs++;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi;
    int per;
    int highs;
    int changes;
    logic p;
    void'($urandom(32'd2024));
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(pwmOut == 1'b0, "R1 pwmOut after reset", pwmOut, 0);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    countHigh(50, highs);
    chk(highs == 0, "R5 stopped after reset", highs, 0);

    runCase(1'b0, 1'b0, 128, 3'd1, 1, "R2 fast o=128 /1");
    runCase(1'b0, 1'b0, 64,  3'd2, 8, "R5 fast o=64 /8");
    runCase(1'b1, 1'b0, 128, 3'd2, 8, "R3 pc o=128 /8");
    runCase(1'b0, 1'b1, 200, 3'd1, 1, "R4 fast inv o=200");
    runCase(1'b1, 1'b1, 10,  3'd1, 1, "R4 pc inv o=10");
    runCase(1'b0, 1'b0, 255, 3'd1, 1, "R7 fast o=255");
    runCase(1'b1, 1'b0, 255, 3'd1, 1, "R7 pc o=255");
    runCase(1'b1, 1'b0, 1,   3'd1, 1, "R3 pc o=1");
    runCase(1'b0, 1'b0, 128, 3'd3, 64, "R5 fast o=128 /64");

    // R7: compare zero keeps output low
    cfg(1'b0, 1'b0, 3'd1);
    wr(2'd1, 8'd0);
    repeat (600) @(negedge clk);
    countHigh(600, highs);
    chk(highs == 0, "R7 fast o=0 high samples", highs, 0);
    cfg(1'b1, 1'b0, 3'd1);
    repeat (1100) @(negedge clk);
    countHigh(1100, highs);
    chk(highs == 0, "R7 pc o=0 high samples", highs, 0);

    // R6: buffered compare write
    cfg(1'b0, 1'b0, 3'd1);
    wr(2'd1, 8'd50);
    measure(hi, per, 1'b0, 8'd0);
    measure(hi, per, 1'b0, 8'd0);
    measure(hi, per, 1'b1, 8'd150);
    chk(hi == 50, "R6 period of write keeps old compare", hi, 50);
    measure(hi, per, 1'b0, 8'd0);
    chk(hi == 150, "R6 next period uses new compare", hi, 150);

    // R5: stop holds output
    wr(2'd1, 8'd128);
    repeat (600) @(negedge clk);
    while (!pwmOut) @(negedge clk);
    cfg(1'b0, 1'b0, 3'd0);
    countHigh(500, highs);
    chk(highs == 500, "R5 code 0 holds high", highs, 500);
    cfg(1'b0, 1'b0, 3'd6);
    countHigh(500, highs);
    chk(highs == 500, "R5 code 6 holds high", highs, 500);
    cfg(1'b0, 1'b0, 3'd7);
    changes = 0; p = pwmOut;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pwmOut != p) changes++;
      p = pwmOut;
    end
    chk(changes == 0, "R5 code 7 no edges", changes, 0);
    cfg(1'b0, 1'b0, 3'd1);
    measure(hi, per, 1'b0, 8'd0);
    measure(hi, per, 1'b0, 8'd0);
    chk(per == 256, "R5 resume period", per, 256);

    // R9 / R8: enable gating and sticky flag
    wr(2'd3, 8'd1);
    wr(2'd1, 8'd100);
    wr(2'd2, 8'd0);
    repeat (600) @(negedge clk);
    chk(irq == 1'b0, "R9 disabled irq stays low", irq, 0);
    wr(2'd2, 8'd1);
    chk(irq == 1'b1, "R9 pending flag raises irq on enable", irq, 1);

    // R8: clear and match collision
    p = pwmOut;
    @(negedge clk);
    while (!(p && !pwmOut)) begin
      p = pwmOut;
      @(negedge clk);
    end
    wr(2'd3, 8'd1);
    chk(irq == 1'b0, "R8 clear drops flag", irq, 0);
    repeat (254) @(negedge clk);
    chk(irq == 1'b0, "R8 flag stays clear before match", irq, 0);
    wr(2'd3, 8'd1);
    chk(irq == 1'b1, "R8 set wins over clear", irq, 1);
    wr(2'd3, 8'd1);
    chk(irq == 1'b0, "R8 lone clear drops flag", irq, 0);
    repeat (300) @(negedge clk);
    chk(irq == 1'b1, "R8 next match sets flag", irq, 1);

    // random configurations at /1
    for (int k = 0; k < 8; k++) begin
      bit m;
      bit v;
      int o;
      m = bit'($urandom % 2);
      v = bit'($urandom % 2);
      o = 1 + int'($urandom % 255);
      runCase(m, v, o, 3'd1, 1, v ? "R4 random" : (m ? "R3 random" : "R2 random"));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule